// File: doc/BRIEF.md
# Pseudo-SRAM Sleep and Partition Controller

This block models the control state of a self-refreshing pseudo-SRAM at the device side. It watches the chip, byte, write and sleep-request pins. It holds a five-bit low-power setup register, which is loaded from the low address lines by any write made while the sleep request is asserted. A clocked delay then decides whether the part drops into deep sleep or keeps refreshing part of the array. The data array and the refresh circuits themselves are outside the block.

The block reports four things. The first is the present power mode. The second is the bounds of the address window being refreshed. The third is whether the current address falls inside the usable window, which shrinks when reduced-size operation is in force. The fourth is a sticky flag that says the array contents were lost in deep sleep. A write grant output is high only for array writes that are allowed. A parameter picks the variant: in one, the register powers up with deep sleep enabled; in the other, with deep sleep disabled.

Top module: `psram_sleep_ctrl`

## Requirements
- R1: After reset, with the chip deselected, `mode` is 1 (standby), `contents_lost` is 0, the refresh window is 0 to all-ones, and `in_window` is 1 for any address.
- R2: Outside the sleep states, `mode` is 1 (standby) when `chip_sel_n` is 1 or `byte_en_n` is 2'b11, and 0 (active) otherwise.
- R3: Suppose `sleep_req_n` is first sampled low at a clock edge, with no write during the delay. Then `mode` keeps its active or standby value through the next DELAY_CYC-1 edges and changes at the DELAY_CYC-th edge after that first one.
- R4: When the delay expires, setup bit 4 set to 0 gives `mode` 3 (deep sleep), and bit 4 set to 1 gives `mode` 2 (partial refresh). Either mode holds while `sleep_req_n` stays low. One edge after `sleep_req_n` is sampled high, `mode` is 0 or 1 again.
- R5: With NO_DEEP_DEFAULT=0, setup bit 4 resets to 0, so a sleep request with no write ends in deep sleep. All other setup bits reset to 0.
- R6: While the delay runs or has been cancelled, a write strobe (chip selected, a byte enabled, `wr_en_n` low) loads `addr[4:0]` into the setup register. A strobe seen before the delay expires cancels sleep entry, and the block stays active or standby until `sleep_req_n` rises.
- R7: Entering deep sleep sets `contents_lost` and restores the setup register to its reset value. `contents_lost` clears on the edge after a granted array write.
- R8: In partial refresh, the refresh window is decoded from the setup bits. Bit 1 = 0 selects the full array. Bit 1 = 1 with bit 0 = 1 selects a quarter, and with bit 0 = 0 a half. Bit 2 = 1 puts that window at the top of the address space, and bit 2 = 0 at the bottom.
- R9: In every mode other than partial refresh, the refresh window is the full array. The stored setup is kept, so the same partial window is used again at the next sleep.
- R10: If setup bit 3 is 1 when `sleep_req_n` rises, reduced-size access takes effect using that rise's window bits. `in_window` is then 0 for addresses outside the window. Reduced-size access stays in force until a later rise finds a rewritten bit 3.
- R11: `wr_grant` is 1 only when the block is awake, `sleep_req_n` is high, a write strobe is present and `in_window` is 1. Writes made in partial refresh or deep sleep are ignored and do not change the setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel_n | input | 1 | Chip select, active low |
| byte_en_n | input | 2 | Byte enables, active low (bit 1 upper, bit 0 lower) |
| wr_en_n | input | 1 | Write strobe, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| addr | input | ADDR_W | Word address; bits 4:0 also carry setup data |
| mode | output | 2 | 0 active, 1 standby, 2 partial refresh, 3 deep sleep |
| refr_lo | output | ADDR_W | Lowest refreshed address |
| refr_hi | output | ADDR_W | Highest refreshed address |
| in_window | output | 1 | Address lies in the usable window |
| wr_grant | output | 1 | Array write allowed this cycle |
| contents_lost | output | 1 | Array data lost in deep sleep |

## Verification
A setup register holding the wrong value shows up only at the next sleep. The `mode` code is wrong one delay period after the request, or the refresh bounds are off as soon as partial refresh begins. So each setup pattern is followed by its own sleep cycle. A wrong wipe or a wrong reduced-size latch appears on `in_window` in the first awake cycle after `sleep_req_n` rises. A bad delay counter moves the `mode` change off its edge by one or more cycles, and the bench samples exactly on both sides of that edge.

// File: rtl/psram_sleep_pkg.sv
// Shared types for the pseudo-SRAM sleep controller.
// Assumes: setup register bit positions match the low address lines.
package psram_sleep_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_PARTIAL = 2'd2,
        MODE_DEEP    = 2'd3
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ARM,
        ST_HOLD,
        ST_PARTIAL,
        ST_DEEP
    } ctl_state_e;

    localparam int CFG_W       = 5;
    localparam int CFG_QUARTER = 0;
    localparam int CFG_SPLIT   = 1;
    localparam int CFG_TOP     = 2;
    localparam int CFG_RMS     = 3;
    localparam int CFG_NO_DEEP = 4;

endpackage

// File: rtl/sleep_delay_timer.sv
// Counts the wait after a sleep request.
// Assumes: run stays high for the whole wait; dropping it clears the count.
module sleep_delay_timer #(
    parameter int DELAY_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Flag the last cycle of the wait.
    assign expire = run && (cnt == LAST);

    // Count cycles while the wait is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mode_cfg_reg.sv
// Low-power setup register with a variant-dependent default.
// Assumes: load and wipe are never high together; wipe has priority.
module mode_cfg_reg
    import psram_sleep_pkg::*;
#(
    parameter bit NO_DEEP_DEFAULT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] load_val,
    input  logic             wipe,
    output logic [CFG_W-1:0] cfg_q
);
    logic [CFG_W-1:0] dflt;

    // Pick the power-up value for the chosen variant.
    generate
        if (NO_DEEP_DEFAULT) begin : g_no_deep
            assign dflt = CFG_W'(1) << CFG_NO_DEEP;
        end else begin : g_deep
            assign dflt = '0;
        end
    endgenerate

    // Hold, restore or load the setup bits.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            cfg_q <= dflt;
        end else if (load) begin
            cfg_q <= load_val;
        end
    end
endmodule

// File: rtl/window_decode.sv
// Decodes the window bits into address bounds.
// Assumes: ADDR_W >= 3.
module window_decode #(
    parameter int ADDR_W = 21
) (
    input  logic              split,
    input  logic              quarter,
    input  logic              top,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam logic [ADDR_W-1:0] ALL1     = '1;
    localparam logic [ADDR_W-1:0] H_BOT_HI = ALL1 >> 1;
    localparam logic [ADDR_W-1:0] Q_BOT_HI = ALL1 >> 2;
    localparam logic [ADDR_W-1:0] H_TOP_LO = ~H_BOT_HI;
    localparam logic [ADDR_W-1:0] Q_TOP_LO = ~Q_BOT_HI;

    // Choose the bounds from size and position.
    always_comb begin
        lo = '0;
        hi = ALL1;
        if (split) begin
            if (top) begin
                lo = quarter ? Q_TOP_LO : H_TOP_LO;
                hi = ALL1;
            end else begin
                lo = '0;
                hi = quarter ? Q_BOT_HI : H_BOT_HI;
            end
        end
    end
endmodule

// File: rtl/psram_sleep_ctrl.sv
// Pseudo-SRAM sleep, partial refresh and reduced-size control state.
// Assumes: pins are synchronous to clk; DELAY_CYC >= 1.
module psram_sleep_ctrl
    import psram_sleep_pkg::*;
#(
    parameter int ADDR_W          = 21,
    parameter int DELAY_CYC       = 50,
    parameter bit NO_DEEP_DEFAULT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic [1:0]        byte_en_n,
    input  logic              wr_en_n,
    input  logic              sleep_req_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        mode,
    output logic [ADDR_W-1:0] refr_lo,
    output logic [ADDR_W-1:0] refr_hi,
    output logic              in_window,
    output logic              wr_grant,
    output logic              contents_lost
);
    ctl_state_e       state, state_nx;
    logic             selected, wr_strobe, expire;
    logic             cfg_load, cfg_wipe, waking;
    logic [CFG_W-1:0] cfg_q;
    logic             acc_rms, acc_split, acc_quarter, acc_top;
    logic [ADDR_W-1:0] dec_lo, dec_hi, acc_lo, acc_hi;

    // Decode chip selection and write strobe.
    assign selected  = !chip_sel_n && (byte_en_n != 2'b11);
    assign wr_strobe = selected && !wr_en_n;

    sleep_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_ARM && !sleep_req_n),
        .expire (expire)
    );

    // Pick the next control state.
    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:  if (!sleep_req_n) state_nx = ST_ARM;
            ST_ARM: begin
                if (sleep_req_n)    state_nx = ST_RUN;
                else if (wr_strobe) state_nx = ST_HOLD;
                else if (expire)    state_nx = cfg_q[CFG_NO_DEEP] ? ST_PARTIAL : ST_DEEP;
            end
            default: if (sleep_req_n) state_nx = ST_RUN;
        endcase
    end

    // Advance the control state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Derive setup load, wipe and wake events.
    assign cfg_load = (state == ST_ARM || state == ST_HOLD) && !sleep_req_n && wr_strobe;
    assign cfg_wipe = (state == ST_ARM) && (state_nx == ST_DEEP);
    assign waking   = (state != ST_RUN) && (state_nx == ST_RUN);

    mode_cfg_reg #(.NO_DEEP_DEFAULT(NO_DEEP_DEFAULT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .load_val (addr[CFG_W-1:0]),
        .wipe     (cfg_wipe),
        .cfg_q    (cfg_q)
    );

    // Latch the reduced-size setting at each wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rms     <= 1'b0;
            acc_split   <= 1'b0;
            acc_quarter <= 1'b0;
            acc_top     <= 1'b0;
        end else if (waking) begin
            acc_rms     <= cfg_q[CFG_RMS];
            acc_split   <= cfg_q[CFG_SPLIT];
            acc_quarter <= cfg_q[CFG_QUARTER];
            acc_top     <= cfg_q[CFG_TOP];
        end
    end

    window_decode #(.ADDR_W(ADDR_W)) u_refr_dec (
        .split   (cfg_q[CFG_SPLIT]),
        .quarter (cfg_q[CFG_QUARTER]),
        .top     (cfg_q[CFG_TOP]),
        .lo      (dec_lo),
        .hi      (dec_hi)
    );

    window_decode #(.ADDR_W(ADDR_W)) u_acc_dec (
        .split   (acc_split),
        .quarter (acc_quarter),
        .top     (acc_top),
        .lo      (acc_lo),
        .hi      (acc_hi)
    );

    // Report refresh bounds, narrowed only in partial refresh.
    always_comb begin
        if (state == ST_PARTIAL) begin
            refr_lo = dec_lo;
            refr_hi = dec_hi;
        end else begin
            refr_lo = '0;
            refr_hi = '1;
        end
    end

    // Check the address against the usable window.
    assign in_window = !acc_rms || ((addr >= acc_lo) && (addr <= acc_hi));

    // Allow array writes only when awake and in range.
    assign wr_grant = (state == ST_RUN) && sleep_req_n && wr_strobe && in_window;

    // Map the control state onto the reported mode.
    always_comb begin
        case (state)
            ST_PARTIAL: mode = MODE_PARTIAL;
            ST_DEEP:    mode = MODE_DEEP;
            default:    mode = selected ? MODE_ACTIVE : MODE_STANDBY;
        endcase
    end

    // Track loss of array data across deep sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)        contents_lost <= 1'b0;
        else if (cfg_wipe) contents_lost <= 1'b1;
        else if (wr_grant) contents_lost <= 1'b0;
    end
endmodule

// File: rtl/psram_sleep_chk.sv
// Temporal properties of the sleep controller, bound to its top.
module psram_sleep_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req_n,
    input logic [1:0]        mode,
    input logic [ADDR_W-1:0] refr_lo,
    input logic [ADDR_W-1:0] refr_hi,
    input logic              in_window,
    input logic              wr_grant,
    input logic              contents_lost
);
    // R4
    wake_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_n |=> (mode == 2'd0 || mode == 2'd1));

    // R7
    deep_marks_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> contents_lost);

    // R9
    full_refresh_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |-> (refr_lo == '0 && refr_hi == '1));

    // R11
    no_grant_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 || mode == 2'd3) |-> !wr_grant);

    // R10
    grant_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> in_window);

    // R7
    grant_clears_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |=> !contents_lost);
endmodule

bind psram_sleep_ctrl psram_sleep_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req_n   (sleep_req_n),
    .mode          (mode),
    .refr_lo       (refr_lo),
    .refr_hi       (refr_hi),
    .in_window     (in_window),
    .wr_grant      (wr_grant),
    .contents_lost (contents_lost)
);

// File: tb/tb_psram_sleep_ctrl.sv
module tb_psram_sleep_ctrl;
    localparam int AW  = 21;
    localparam int DLY = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1;
    logic [1:0]    byte_en_n = 2'b11;
    logic          wr_en_n = 1'b1;
    logic          sleep_req_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    mode;
    logic [AW-1:0] refr_lo, refr_hi;
    logic          in_window, wr_grant, contents_lost;
    int            n_chk = 0;
    int            n_bad = 0;

    always #10 clk = ~clk;

    psram_sleep_ctrl #(.ADDR_W(AW), .DELAY_CYC(DLY), .NO_DEEP_DEFAULT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .byte_en_n(byte_en_n),
        .wr_en_n(wr_en_n), .sleep_req_n(sleep_req_n), .addr(addr), .mode(mode),
        .refr_lo(refr_lo), .refr_hi(refr_hi), .in_window(in_window),
        .wr_grant(wr_grant), .contents_lost(contents_lost)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        chip_sel_n = 1'b1; byte_en_n = 2'b11; wr_en_n = 1'b1; addr = '0;
    endtask

    // Write a setup value during sleep request, then release it.
    task automatic load_setup(input logic [4:0] val);
        idle();
        sleep_req_n = 1'b0;
        tick(2);
        chip_sel_n = 1'b0; byte_en_n = 2'b00; wr_en_n = 1'b0; addr = AW'(val);
        tick(1);
        idle();
        tick(DLY + 2);
        check("R6 cancelled sleep", 32'(mode), 32'd1);
        sleep_req_n = 1'b1;
        tick(1);
    endtask

    // Sleep with no write; check mode and refresh window.
    task automatic sleep_check(input logic [1:0] exp_mode, input logic [31:0] lo,
                               input logic [31:0] hi, input string req);
        idle();
        sleep_req_n = 1'b0;
        tick(DLY + 1);
        check(req, 32'(mode), 32'(exp_mode));
        check(req, 32'(refr_lo), lo);
        check(req, 32'(refr_hi), hi);
        sleep_req_n = 1'b1;
        tick(1);
        check("R4 wake", 32'(mode), 32'd1);
        check("R9 full after wake", 32'(refr_hi), 32'h1FFFFF);
    endtask

    task automatic t_reset();
        tick(1);
        check("R1 mode", 32'(mode), 32'd1);
        check("R1 lost", 32'(contents_lost), 32'd0);
        check("R1 lo", 32'(refr_lo), 32'd0);
        check("R1 hi", 32'(refr_hi), 32'h1FFFFF);
        addr = 21'h1ABCDE;
        tick(0);
        check("R1 in_window", 32'(in_window), 32'd1);
    endtask

    task automatic t_select();
        chip_sel_n = 1'b0; byte_en_n = 2'b10; tick(0);
        check("R2 active lower", 32'(mode), 32'd0);
        byte_en_n = 2'b01; tick(0);
        check("R2 active upper", 32'(mode), 32'd0);
        byte_en_n = 2'b11; tick(0);
        check("R2 bytes off", 32'(mode), 32'd1);
        chip_sel_n = 1'b1; byte_en_n = 2'b00; tick(0);
        check("R2 chip off", 32'(mode), 32'd1);
        idle();
    endtask

    task automatic t_deep_default();
        idle();
        sleep_req_n = 1'b0;
        tick(DLY);
        check("R3 before expiry", 32'(mode), 32'd1);
        tick(1);
        check("R3 R5 deep at expiry", 32'(mode), 32'd3);
        check("R7 lost set", 32'(contents_lost), 32'd1);
        tick(5);
        check("R4 holds", 32'(mode), 32'd3);
        chip_sel_n = 1'b0; byte_en_n = 2'b00; wr_en_n = 1'b0; tick(0);
        check("R11 no grant in deep", 32'(wr_grant), 32'd0);
        idle();
        sleep_req_n = 1'b1;
        tick(1);
        check("R4 wake", 32'(mode), 32'd1);
    endtask

    task automatic t_clear_lost();
        chip_sel_n = 1'b0; byte_en_n = 2'b00; wr_en_n = 1'b0; addr = 21'h1F0000; tick(0);
        check("R11 grant awake", 32'(wr_grant), 32'd1);
        tick(1);
        idle();
        check("R7 lost cleared", 32'(contents_lost), 32'd0);
    endtask

    task automatic t_partial_windows();
        load_setup(5'b10111);
        sleep_check(2'd2, 32'h180000, 32'h1FFFFF, "R8 top quarter");
        sleep_check(2'd2, 32'h180000, 32'h1FFFFF, "R9 kept");
        // Write during partial refresh must be ignored.
        sleep_req_n = 1'b0;
        tick(DLY + 1);
        chip_sel_n = 1'b0; byte_en_n = 2'b00; wr_en_n = 1'b0; addr = 21'h00000;
        tick(0);
        check("R11 no grant partial", 32'(wr_grant), 32'd0);
        tick(2);
        idle();
        sleep_req_n = 1'b1;
        tick(1);
        sleep_check(2'd2, 32'h180000, 32'h1FFFFF, "R11 setup unchanged");
        load_setup(5'b10011);
        sleep_check(2'd2, 32'h000000, 32'h07FFFF, "R8 bottom quarter");
        load_setup(5'b10010);
        sleep_check(2'd2, 32'h000000, 32'h0FFFFF, "R8 bottom half");
        load_setup(5'b10110);
        sleep_check(2'd2, 32'h100000, 32'h1FFFFF, "R8 top half");
        load_setup(5'b10100);
        sleep_check(2'd2, 32'h000000, 32'h1FFFFF, "R8 full");
    endtask

    task automatic t_reduced();
        idle();
        sleep_req_n = 1'b0;
        tick(2);
        chip_sel_n = 1'b0; byte_en_n = 2'b00; wr_en_n = 1'b0; addr = 21'h1B;
        tick(1);
        idle();
        addr = 21'h100000; tick(0);
        check("R10 not before rise", 32'(in_window), 32'd1);
        sleep_req_n = 1'b1;
        tick(1);
        addr = 21'h07FFFF; tick(0);
        check("R10 edge inside", 32'(in_window), 32'd1);
        addr = 21'h080000; tick(0);
        check("R10 outside", 32'(in_window), 32'd0);
        chip_sel_n = 1'b0; byte_en_n = 2'b00; wr_en_n = 1'b0; tick(0);
        check("R10 write blocked", 32'(wr_grant), 32'd0);
        addr = 21'h000010; tick(0);
        check("R10 write inside", 32'(wr_grant), 32'd1);
        idle();
        sleep_check(2'd2, 32'h000000, 32'h07FFFF, "R10 persists");
        addr = 21'h1FFFFF; tick(0);
        check("R10 still reduced", 32'(in_window), 32'd0);
        // Enable deep sleep and keep reduced size; deep entry must wipe it.
        load_setup(5'b01011);
        addr = 21'h1FFFFF; tick(0);
        check("R10 still reduced after rewrite", 32'(in_window), 32'd0);
        sleep_check(2'd3, 32'h0, 32'h1FFFFF, "R4 deep selected");
        addr = 21'h1FFFFF; tick(0);
        check("R7 wipe clears reduced", 32'(in_window), 32'd1);
        sleep_check(2'd3, 32'h0, 32'h1FFFFF, "R7 R5 default after wipe");
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_deep_default();
        t_clear_lost();
        t_partial_windows();
        t_reduced();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule